// File: doc/BRIEF.md
# QoS Priority Request Arbiter

This block shares one slave address channel among several requesters. Each requester drives a valid, a 4-bit quality-of-service level and an address payload. The requester with the highest level among those with valid high is chosen. Its payload is forwarded downstream and the downstream ready is returned to that requester alone. A transfer takes place on a rising clock edge on which the downstream valid and ready are both high.

Once the block presents a request downstream, its choice stays fixed until that transfer completes. A more urgent request that arrives while the block waits therefore wins the following arbitration, not the current one. When several requesters share the top level, a rotating pointer decides among them. The block holds no storage for the request itself: valid, payload and ready pass through combinational paths.

Requesters must follow the usual handshake rule. A valid, once raised, stays high with the same level and payload until its transfer.

Top module: `qos_req_arbiter`

## Requirements
- R1: After reset no requester is chosen, every req_ready is low, out_valid is low while no requester is valid, and the tie pointer starts at requester 0.
- R2: Requester i's level is req_qos[4i+3:4i], an unsigned value from 0 (lowest) to 15 (highest). When no grant is held, the chosen requester has the largest level among the requesters with valid high.
- R3: out_valid is high exactly when the chosen requester's valid is high. Under the handshake rule this equals the OR of all req_valid bits, in the same cycle.
- R4: req_ready[i] is high only when requester i is chosen, out_valid is high and out_ready is high. At most one req_ready bit is high.
- R5: out_payload equals the chosen requester's slot req_payload[PW*i +: PW] in the same cycle. It stays stable while out_valid is high and out_ready is low.
- R6: If out_valid is high and out_ready is low at a clock edge, the same requester stays chosen in the next cycle, even if a requester with a higher level has become valid.
- R7: Among valid requesters tied at the top level, the first index at or after the pointer wins, wrapping past N-1 to 0. After each transfer the pointer moves to the winner's index plus one, modulo N.
- R8: With requests at levels 15, 8 and 4 pending and out_ready held high, transfers complete on three consecutive cycles in the order 15, 8, 4.
- R9: A level-15 request that arrives while a lower-level grant is held wins the arbitration right after that held transfer.
- R10: A requester whose valid is low is never chosen and never gets ready, whatever its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Per-requester request valid |
| req_qos | input | 4*N_REQ | Per-requester priority level, 4 bits per slot |
| req_payload | input | PAY_W*N_REQ | Per-requester address payload |
| req_ready | output | N_REQ | Per-requester accept, high only for the chosen one |
| out_valid | output | 1 | Downstream request valid |
| out_payload | output | PAY_W | Downstream payload of the chosen requester |
| out_ready | input | 1 | Downstream accept |

## Verification
Every cycle, the assertions check four things. At most one req_ready is high, and only for a valid requester with out_ready high. An unheld choice has the top level among the valid requesters. A stalled cycle keeps both the choice and the payload for the next cycle. The order of grants over many transfers is visible only to the bench's reference model. This covers the tie pointer's rotation, the order 15, 8, 4, and a late level-15 request winning only after the held transfer. The bench compares the model with the ports under random stimulus and in directed scenarios.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
  localparam int QOS_W = 4;
  typedef logic [QOS_W-1:0] qos_t;

  // next index after idx in a ring of n slots
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // true when level a outranks level b
  function automatic logic qos_above(input qos_t a, input qos_t b);
    return a > b;
  endfunction
endpackage

// File: rtl/qarb_qos_scan.sv
module qarb_qos_scan
  import qarb_pkg::*;
#(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0]       req_valid,
  input  logic [N_REQ*QOS_W-1:0] req_qos,
  output qos_t                   top_qos,
  output logic [N_REQ-1:0]       cand
);
  qos_t lvl [N_REQ];

  for (genvar i = 0; i < N_REQ; i++) begin : g_unpack
    assign lvl[i] = req_qos[i*QOS_W +: QOS_W];
  end

  // highest level among the active slots (0 when none is active)
  always_comb begin
    top_qos = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req_valid[i] && qos_above(lvl[i], top_qos)) top_qos = lvl[i];
    end
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_cand
    assign cand[i] = req_valid[i] && (lvl[i] == top_qos);
  end
endmodule

// File: rtl/qarb_rr_pick.sv
module qarb_rr_pick #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] cand,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] pick,
  output logic             pick_any
);
  // first set bit of mask at or after start, wrapping
  function automatic logic [IDX_W-1:0] first_from(input logic [N_REQ-1:0] mask,
                                                  input logic [IDX_W-1:0] start);
    logic [IDX_W-1:0] res;
    logic             hit;
    int               j;
    res = '0;
    hit = 1'b0;
    for (int k = 0; k < N_REQ; k++) begin
      j = int'(start) + k;
      if (j >= N_REQ) j = j - N_REQ;
      if (!hit && mask[j]) begin
        hit = 1'b1;
        res = j[IDX_W-1:0];
      end
    end
    return res;
  endfunction

  assign pick     = first_from(cand, ptr);
  assign pick_any = |cand;
endmodule

// File: rtl/qarb_grant_hold.sv
module qarb_grant_hold
  import qarb_pkg::*;
#(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pick,
  input  logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] grant,
  output logic             locked,
  output logic [IDX_W-1:0] ptr
);
  logic             locked_q;
  logic [IDX_W-1:0] held_q;
  logic [IDX_W-1:0] ptr_q;
  logic             xfer_evt;
  logic             stall_evt;

  assign grant     = locked_q ? held_q : pick;
  assign xfer_evt  = out_valid && out_ready;
  assign stall_evt = out_valid && !out_ready;
  assign locked    = locked_q;
  assign ptr       = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      held_q   <= '0;
      ptr_q    <= '0;
    end else if (xfer_evt) begin
      locked_q <= 1'b0;
      ptr_q    <= IDX_W'(ring_next(int'(grant), N_REQ));
    end else if (stall_evt) begin
      locked_q <= 1'b1;
      held_q   <= grant;
    end else begin
      locked_q <= 1'b0;
    end
  end

  // R6: a stalled request keeps its grant in the next cycle
  assert_grant_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> (grant == $past(grant)));

  // R7: a transfer never leaves the pointer on the same winner (N > 1)
  assert_ptr_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_evt && N_REQ > 1) |=> (ptr_q != $past(grant)));
endmodule

// File: rtl/qos_req_arbiter.sv
module qos_req_arbiter
  import qarb_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int PAY_W = 32,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REQ-1:0]       req_valid,
  input  logic [N_REQ*QOS_W-1:0] req_qos,
  input  logic [N_REQ*PAY_W-1:0] req_payload,
  output logic [N_REQ-1:0]       req_ready,
  output logic                   out_valid,
  output logic [PAY_W-1:0]       out_payload,
  input  logic                   out_ready
);
  qos_t             top_qos;
  logic [N_REQ-1:0] cand;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] pick;
  logic             pick_any;
  logic [IDX_W-1:0] grant;
  logic             locked;
  logic [PAY_W-1:0] pay  [N_REQ];
  qos_t             lvl  [N_REQ];
  qos_t             grant_qos;

  qarb_qos_scan #(.N_REQ(N_REQ)) u_scan (
    .req_valid (req_valid),
    .req_qos   (req_qos),
    .top_qos   (top_qos),
    .cand      (cand)
  );

  qarb_rr_pick #(.N_REQ(N_REQ)) u_pick (
    .cand     (cand),
    .ptr      (ptr),
    .pick     (pick),
    .pick_any (pick_any)
  );

  qarb_grant_hold #(.N_REQ(N_REQ)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick      (pick),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .grant     (grant),
    .locked    (locked),
    .ptr       (ptr)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    assign pay[i]       = req_payload[i*PAY_W +: PAY_W];
    assign lvl[i]       = req_qos[i*QOS_W +: QOS_W];
    assign req_ready[i] = out_valid && out_ready && (grant == IDX_W'(i));
  end

  assign out_valid   = req_valid[grant];
  assign out_payload = pay[grant];
  assign grant_qos   = lvl[grant];

  // R4: ready reaches at most one requester, and only with downstream ready
  assert_ready_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready) && ((|req_ready) -> out_ready));

  // R10: an idle requester never receives ready
  assert_idle_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R2: an unheld choice carries the top active level
  assert_top_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !locked) |-> (pick_any && grant_qos == top_qos));

  // R3: downstream valid tracks any active requester
  assert_valid_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (|req_valid));

  // R5: payload frozen across a stall
  assert_payload_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_payload));
endmodule

// File: tb/qos_req_arbiter_bench.sv
module qos_req_arbiter_bench;
  localparam int N = 4;
  localparam int PW = 16;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      req_valid;
  logic [N*4-1:0]    req_qos;
  logic [N*PW-1:0]   req_payload;
  logic [N-1:0]      req_ready;
  logic              out_valid;
  logic [PW-1:0]     out_payload;
  logic              out_ready;

  logic              bv [N];
  logic [3:0]        bq [N];
  logic [PW-1:0]     bp [N];
  logic              b_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  int m_locked = 0;
  int m_held = 0;
  int m_ptr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]              = bv[i];
      req_qos[i*4 +: 4]         = bq[i];
      req_payload[i*PW +: PW]   = bp[i];
    end
    out_ready = b_ready;
  end

  qos_req_arbiter #(.N_REQ(N), .PAY_W(PW)) u_qos_req_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_qos     (req_qos),
    .req_payload (req_payload),
    .req_ready   (req_ready),
    .out_valid   (out_valid),
    .out_payload (out_payload),
    .out_ready   (out_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference choice: scan from the pointer, keep a strictly higher level
  function automatic int ref_grant();
    int best;
    int j;
    if (m_locked != 0) return m_held;
    best = -1;
    for (int k = 0; k < N; k++) begin
      j = (m_ptr + k) % N;
      if (bv[j] && (best < 0 || bq[j] > bq[best])) best = j;
    end
    return best;
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      bv[i] = 1'b0;
      bq[i] = 4'd0;
      bp[i] = PW'(16'h0A00 + i);
    end
  endtask

  task automatic set_req(input int i, input int lvl, input int tagv);
    bv[i] = 1'b1;
    bq[i] = lvl[3:0];
    bp[i] = PW'((tagv << 4) | i);
  endtask

  // called just after a negedge with inputs settled; checks, then retires
  task automatic step(input string tag, output int g);
    logic [N-1:0] exp_rdy;
    #1;
    g = ref_grant();
    check(out_valid == (g >= 0), "R3", "out_valid", out_valid, (g >= 0));
    if (g >= 0)
      check(out_payload == bp[g], tag, "payload/grantee", out_payload, bp[g]);
    exp_rdy = '0;
    if (g >= 0 && b_ready) exp_rdy[g] = 1'b1;
    check(req_ready == exp_rdy, "R4", "req_ready", req_ready, exp_rdy);
    @(posedge clk);
    @(negedge clk);
    if (g >= 0) begin
      if (b_ready) begin
        m_locked = 0;
        m_ptr = (g + 1) % N;
        bv[g] = 1'b0;
      end else begin
        m_locked = 1;
        m_held = g;
      end
    end else begin
      m_locked = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int g;
    void'($urandom(32'd2024));
    clear_all();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: idle after reset
    check(out_valid == 1'b0, "R1", "out_valid idle", out_valid, 0);
    check(req_ready == '0, "R1", "req_ready idle", req_ready, 0);

    // R7 / R1: four-way tie, pointer from 0, rotates each transfer
    @(negedge clk);
    for (int i = 0; i < N; i++) set_req(i, 7, 1);
    b_ready = 1'b1;
    for (int k = 0; k < N; k++) begin
      step("R7", g);
      check(g == k, "R7", "tie order (R1 pointer start)", g, k);
    end

    // R8: levels 15, 8, 4 drain in that order on consecutive cycles
    clear_all();
    set_req(0, 4, 2);
    set_req(1, 15, 2);
    set_req(2, 8, 2);
    step("R8", g); check(g == 1, "R8", "first level 15", g, 1);
    step("R8", g); check(g == 2, "R8", "second level 8", g, 2);
    step("R8", g); check(g == 0, "R8", "third level 4", g, 0);

    // R6 / R9: held grant survives a late 15, which wins afterwards
    clear_all();
    set_req(0, 5, 3);
    set_req(1, 3, 3);
    b_ready = 1'b0;
    step("R2", g); check(g == 0, "R2", "top level 5", g, 0);
    set_req(3, 15, 3);
    step("R6", g); check(g == 0, "R6", "held under late 15", g, 0);
    check(out_payload == bp[0], "R6", "held payload", out_payload, bp[0]);
    b_ready = 1'b1;
    step("R6", g); check(g == 0, "R6", "held transfer", g, 0);
    step("R9", g); check(g == 3, "R9", "late 15 wins next", g, 3);
    step("R2", g); check(g == 1, "R2", "remaining level 3", g, 1);

    // R10: inactive requester with top level is ignored
    clear_all();
    bq[2] = 4'd15;
    bp[2] = PW'(16'hBEE2);
    set_req(1, 2, 4);
    b_ready = 1'b1;
    #1;
    check(req_ready[2] == 1'b0, "R10", "idle slot ready", req_ready[2], 0);
    step("R10", g); check(g == 1, "R10", "idle 15 ignored", g, 1);
    bq[2] = 4'd0;

    // random phase: R2 / R5 / R7 against the reference model
    clear_all();
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (!bv[i] && ($urandom % 3) == 0) begin
          bv[i] = 1'b1;
          bq[i] = (($urandom % 2) == 0) ? 4'($urandom % 16) : 4'(($urandom % 2) * 9);
          bp[i] = PW'(($urandom << 2) | i);
        end
      end
      b_ready = (($urandom % 4) != 0);
      step("R5", g);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule